// File: doc/BRIEF.md
# UART Receive Character-Timeout Interrupt Logic

This block sits next to the receive FIFO of a 16550-style UART. It watches the stream of received characters and processor reads. It raises a character-timeout interrupt when characters sit in the FIFO below the trigger level and nothing has happened for four whole character times. The timer counts ticks of the 16x oversampling clock, so the limit follows the programmed frame format, including a stop bit and a half.

The block also produces the receive part of the interrupt-identification code and the data-ready status bit. Software that sees the timeout code can always find at least one character waiting. The deserializer, the FIFO storage and the transmitter live elsewhere. The block only takes their strobes, the FIFO level and the transmitter's empty-request flag.

Top module: `uart_rx_timeout`

## Requirements
- R1: A timeout can only be pending when, in the previous cycle, the FIFO was enabled, the receive interrupt was enabled, the trigger level was above one and the FIFO level was non-zero.
- R2: The limit is four character times, counted in 16x ticks. One character is 1 start bit, 5 to 8 data bits (`word_len` 0..3), 1 parity bit if `parity_on`, and stop bits: 1 stop bit when `long_stop`=0, 1.5 when `long_stop`=1 with 5 data bits, and 2 otherwise. The pending flag rises on the clock edge that consumes the limit-th tick after the last restart. The limits are 640 ticks for 8N1, 704 for 8N2, 480 for 5N1.5 and 768 for 8E2.
- R3: A received-character strobe restarts the timer, and it does not clear a timeout that is already pending.
- R4: A processor-read strobe clears a pending timeout on the next edge and restarts the timer.
- R5: With `trig_sel`=0 (trigger level 1) no timeout is ever raised. The trigger codes 0, 1, 2 and 3 select levels 1, 4, 8 and 14.
- R6: A pending timeout is cleared on the edge after the FIFO level becomes zero, and the timer stays at zero while the FIFO is empty.
- R7: `iir_code` bits 7:6 are 11 when the FIFO is enabled and 00 otherwise. Bits 3:0 follow this priority: 0x4 when `rx_irq_en` is set and the level is at or above the trigger level (level 1 when the FIFO is disabled), then 0xC for a pending timeout, then 0x2 for `tx_empty_irq`, and 0x1 when no source is active. Bits 5:4 are 0.
- R8: `data_ready` is 1 exactly when the FIFO level is non-zero, and the timeout code is reported only while `data_ready` is 1.
- R9: When a tick arrives in the same cycle as a character or read strobe, the restart wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_char_stb | input | 1 | One-cycle pulse per character written into the FIFO |
| rx_read_stb | input | 1 | One-cycle pulse per processor read of the receive buffer |
| fifo_level | input | LVL_W (5) | Current FIFO occupancy |
| word_len | input | 2 | Data bits minus five |
| parity_on | input | 1 | Parity bit present in the frame |
| long_stop | input | 1 | Extended stop (1.5 or 2 bits) |
| os_tick | input | 1 | 16x oversampling tick |
| trig_sel | input | 2 | Receive trigger-level code |
| fifo_on | input | 1 | FIFO mode enabled |
| rx_irq_en | input | 1 | Receive-data interrupt enable |
| tx_empty_irq | input | 1 | Transmitter-holding-empty source active |
| to_pending | output | 1 | Character timeout pending |
| iir_code | output | 8 | Interrupt identification code |
| data_ready | output | 1 | Line-status data-ready bit |

## Verification
Restarting the timer and counting a tick can fall in the same cycle. So can a read that clears a pending flag and a new character arriving. The bench counts the timer up to one tick short of the limit and then drives a tick together with a read strobe. After that it expects a full limit of further ticks before the flag rises. In a second case it pulses a character and a read together while a timeout is pending, and the flag must drop.

// File: rtl/uart_cto_pkg.sv
// Package: shared constants and decode helpers for the receive
// character-timeout logic. Assumes a power-of-two oversampling ratio.
package uart_cto_pkg;

    // Longest frame in half bit times: 1 + 8 + 1 + 2 bits = 12 bits.
    localparam int MAX_HALF_BITS = 24;

    // Receive trigger-level code to FIFO level.
    function automatic int trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    // Interrupt source codes, low nibble of the identification code.
    localparam logic [3:0] SRC_NONE = 4'h1;
    localparam logic [3:0] SRC_THRE = 4'h2;
    localparam logic [3:0] SRC_RDA  = 4'h4;
    localparam logic [3:0] SRC_CTO  = 4'hC;

endpackage

// File: rtl/cto_frame_len.sv
// Frame-length scaler: turns the programmed frame format into the
// timeout limit, four character times counted in oversampling ticks.
// Works in half bit times so that a stop bit and a half is exact.
// Assumes OVS is a power of two.
module cto_frame_len #(
    parameter int OVS   = 16,
    parameter int TMR_W = 10
) (
    input  logic [1:0]       word_len,
    input  logic             parity_on,
    input  logic             long_stop,
    output logic [TMR_W-1:0] limit
);
    localparam int SHIFT = $clog2(OVS) + 1;

    logic [4:0] half_bits;
    logic [4:0] stop_half;

    // Pick the stop length in half bits: 2, 3 (5-bit words) or 4.
    always_comb begin
        if (!long_stop)           stop_half = 5'd2;
        else if (word_len == 2'd0) stop_half = 5'd3;
        else                      stop_half = 5'd4;
    end

    // Sum start, data and parity in half bits, then scale by 4 * OVS / 2.
    always_comb begin
        half_bits = 5'd12 + {2'b00, word_len, 1'b0} + {3'b000, parity_on, 1'b0} + stop_half;
        limit     = TMR_W'(half_bits) << SHIFT;
    end
endmodule

// File: rtl/cto_timer.sv
// Timeout timer: counts oversampling ticks while armed, restarts on a
// received character or a processor read, and raises a sticky pending
// flag at the limit. Only a read, or disarming, clears the flag.
module cto_timer #(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             char_stb,
    input  logic             read_stb,
    input  logic             tick,
    input  logic [TMR_W-1:0] limit,
    output logic             pend
);
    logic [TMR_W-1:0] cnt;
    logic [TMR_W-1:0] cnt_inc;
    logic             restart;
    logic             at_limit;
    logic             hit;

    // Work out whether this cycle's tick completes the interval.
    always_comb begin
        restart  = char_stb | read_stb;
        at_limit = (cnt >= limit);
        cnt_inc  = cnt + TMR_W'(1);
        hit      = tick && !restart && (cnt_inc >= limit);
    end

    // Tick counter: hold at zero when disarmed, restart on activity, saturate.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (!armed || restart)   cnt <= '0;
        else if (tick && !at_limit)   cnt <= cnt_inc;
    end

    // Pending flag: set at the limit, cleared by a read or by disarming.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pend <= 1'b0;
        else if (!armed || read_stb)  pend <= 1'b0;
        else if (hit)                 pend <= 1'b1;
    end
endmodule

// File: rtl/cto_status_enc.sv
// Status encoder: builds the receive part of the interrupt
// identification code and the data-ready bit from the FIFO level,
// the enables and the pending timeout. Receive data available outranks
// the timeout, which outranks the transmitter-empty source.
module cto_status_enc
    import uart_cto_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [1:0]       trig_sel,
    input  logic             fifo_on,
    input  logic             rx_irq_en,
    input  logic             tx_empty_irq,
    input  logic             pend,
    output logic [7:0]       iir_code,
    output logic             data_ready
);
    logic [LVL_W-1:0] trig_lvl;
    logic             rda;
    logic             cto;
    logic [3:0]       src;

    // Effective trigger level: the programmed level in FIFO mode, else one.
    always_comb begin
        trig_lvl = fifo_on ? LVL_W'(trig_level(trig_sel)) : LVL_W'(1);
    end

    // Qualify each receive source.
    always_comb begin
        data_ready = (fifo_level != '0);
        rda        = rx_irq_en && data_ready && (fifo_level >= trig_lvl);
        cto        = pend && fifo_on && data_ready;
    end

    // Prioritised source selection.
    always_comb begin
        if (rda)               src = SRC_RDA;
        else if (cto)          src = SRC_CTO;
        else if (tx_empty_irq) src = SRC_THRE;
        else                   src = SRC_NONE;
    end

    // Assemble the code with the FIFO-mode marker bits.
    always_comb begin
        iir_code = {fifo_on, fifo_on, 2'b00, src};
    end
endmodule

// File: rtl/uart_rx_timeout.sv
// Top: receive character-timeout interrupt logic. Arms the timer only
// in FIFO mode with the receive interrupt on, a trigger level above one
// and data in the FIFO. Assumes the strobes are single-cycle pulses
// synchronous to clk.
module uart_rx_timeout #(
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
    parameter int TMR_W      = $clog2(2 * OVS * uart_cto_pkg::MAX_HALF_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_char_stb,
    input  logic             rx_read_stb,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [1:0]       word_len,
    input  logic             parity_on,
    input  logic             long_stop,
    input  logic             os_tick,
    input  logic [1:0]       trig_sel,
    input  logic             fifo_on,
    input  logic             rx_irq_en,
    input  logic             tx_empty_irq,
    output logic             to_pending,
    output logic [7:0]       iir_code,
    output logic             data_ready
);
    logic [TMR_W-1:0] limit;
    logic             armed;

    // Arming condition for the timer.
    always_comb begin
        armed = fifo_on && rx_irq_en && (trig_sel != 2'd0) && (fifo_level != '0);
    end

    cto_frame_len #(.OVS(OVS), .TMR_W(TMR_W)) u_len (
        .word_len  (word_len),
        .parity_on (parity_on),
        .long_stop (long_stop),
        .limit     (limit)
    );

    cto_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .char_stb (rx_char_stb),
        .read_stb (rx_read_stb),
        .tick     (os_tick),
        .limit    (limit),
        .pend     (to_pending)
    );

    cto_status_enc #(.LVL_W(LVL_W)) u_enc (
        .fifo_level   (fifo_level),
        .trig_sel     (trig_sel),
        .fifo_on      (fifo_on),
        .rx_irq_en    (rx_irq_en),
        .tx_empty_irq (tx_empty_irq),
        .pend         (to_pending),
        .iir_code     (iir_code),
        .data_ready   (data_ready)
    );
endmodule

// File: rtl/uart_rx_timeout_chk.sv
// Checker: temporal properties of the timeout logic, bound to the top.
module uart_rx_timeout_chk
    import uart_cto_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_char_stb,
    input logic             rx_read_stb,
    input logic [LVL_W-1:0] fifo_level,
    input logic             os_tick,
    input logic [1:0]       trig_sel,
    input logic             fifo_on,
    input logic             rx_irq_en,
    input logic             to_pending,
    input logic [7:0]       iir_code,
    input logic             data_ready
);
    // R1
    armed_before_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_pending) |-> $past(fifo_on && rx_irq_en && trig_sel != 2'd0 && fifo_level != '0));

    // R2
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_pending) |-> $past(os_tick));

    // R3
    char_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_stb && !to_pending) |=> !to_pending);

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_read_stb |=> !to_pending);

    // R6
    empty_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |=> !to_pending);

    // R7
    rda_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq_en && fifo_on && fifo_level != '0 &&
         int'(fifo_level) >= trig_level(trig_sel)) |-> (iir_code[3:0] == SRC_RDA));

    // R8
    cto_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_code[3:0] == SRC_CTO) |-> (data_ready && to_pending));
endmodule

bind uart_rx_timeout uart_rx_timeout_chk #(.LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_char_stb (rx_char_stb),
    .rx_read_stb (rx_read_stb),
    .fifo_level  (fifo_level),
    .os_tick     (os_tick),
    .trig_sel    (trig_sel),
    .fifo_on     (fifo_on),
    .rx_irq_en   (rx_irq_en),
    .to_pending  (to_pending),
    .iir_code    (iir_code),
    .data_ready  (data_ready)
);

// File: tb/uart_rx_timeout_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module uart_rx_timeout_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_char_stb, rx_read_stb, parity_on, long_stop, os_tick;
    logic       fifo_on, rx_irq_en, tx_empty_irq;
    logic [4:0] fifo_level;
    logic [1:0] word_len, trig_sel;
    logic       to_pending, data_ready;
    logic [7:0] iir_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    uart_rx_timeout u_uart_rx_timeout (
        .clk(clk), .rst_n(rst_n), .rx_char_stb(rx_char_stb), .rx_read_stb(rx_read_stb),
        .fifo_level(fifo_level), .word_len(word_len), .parity_on(parity_on),
        .long_stop(long_stop), .os_tick(os_tick), .trig_sel(trig_sel), .fifo_on(fifo_on),
        .rx_irq_en(rx_irq_en), .tx_empty_irq(tx_empty_irq), .to_pending(to_pending),
        .iir_code(iir_code), .data_ready(data_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FIFO check FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_char_stb = 0; rx_read_stb = 0; os_tick = 0;
        fifo_level = 0; word_len = 2'd3; parity_on = 0; long_stop = 0;
        trig_sel = 2'd1; fifo_on = 1; rx_irq_en = 1; tx_empty_irq = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            os_tick = 1'b1;
        end
        @(negedge clk);
        os_tick = 1'b0;
    endtask

    task automatic put_char(input logic [4:0] new_level);
        @(negedge clk);
        rx_char_stb = 1'b1; fifo_level = new_level;
        @(negedge clk);
        rx_char_stb = 1'b0;
    endtask

    task automatic cpu_read(input logic [4:0] new_level);
        @(negedge clk);
        rx_read_stb = 1'b1; fifo_level = new_level;
        @(negedge clk);
        rx_read_stb = 1'b0;
    endtask

    // Check that the limit-th tick, and not the one before, raises the flag.
    task automatic limit_edge(input string req, input int lim);
        run_ticks(lim - 1);
        chk(req, to_pending, 0);
        run_ticks(1);
        chk(req, to_pending, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rx_char_stb = 0; rx_read_stb = 0; os_tick = 0;
        fifo_level = 0; word_len = 0; parity_on = 0; long_stop = 0;
        trig_sel = 0; fifo_on = 0; rx_irq_en = 0; tx_empty_irq = 0;
        repeat (2) @(negedge clk);
        chk("R7 reset iir", iir_code, 8'h01);
        chk("R8 reset data_ready", data_ready, 0);
        chk("R1 reset pending", to_pending, 0);
    endtask

    task automatic t_8n1();
        do_reset();
        put_char(5'd1);
        limit_edge("R2 8N1", 640);
        chk("R7 timeout code", iir_code, 8'hCC);
        chk("R8 data_ready with timeout", data_ready, 1);
    endtask

    task automatic t_read_clear();
        do_reset();
        put_char(5'd1); put_char(5'd2);
        run_ticks(640);
        chk("R4 pending before read", to_pending, 1);
        cpu_read(5'd1);
        chk("R4 read clears", to_pending, 0);
        limit_edge("R4 restart after read", 640);
    endtask

    task automatic t_formats();
        do_reset();
        long_stop = 1;
        put_char(5'd1);
        limit_edge("R2 8N2", 704);
        do_reset();
        word_len = 0; long_stop = 1;
        put_char(5'd1);
        limit_edge("R2 5N1.5", 480);
        do_reset();
        parity_on = 1; long_stop = 1;
        put_char(5'd1);
        limit_edge("R2 8E2", 768);
    endtask

    task automatic t_char_restart();
        do_reset();
        put_char(5'd1);
        run_ticks(300);
        put_char(5'd2);
        limit_edge("R3 char restarts timer", 640);
        put_char(5'd3);
        chk("R3 char keeps pending", to_pending, 1);
    endtask

    task automatic t_trig_one();
        do_reset();
        trig_sel = 2'd0;
        put_char(5'd1);
        run_ticks(800);
        chk("R5 trigger one no timeout", to_pending, 0);
        chk("R7 rda at level one", iir_code, 8'hC4);
    endtask

    task automatic t_empty();
        do_reset();
        put_char(5'd1);
        run_ticks(640);
        chk("R6 pending before drain", to_pending, 1);
        @(negedge clk);
        fifo_level = 5'd0;
        chk("R8 data_ready drops", data_ready, 0);
        @(negedge clk);
        chk("R6 empty clears", to_pending, 0);
        chk("R6 empty iir", iir_code, 8'hC1);
        run_ticks(700);
        fifo_level = 5'd1;
        run_ticks(639);
        chk("R6 timer held while empty", to_pending, 0);
    endtask

    task automatic t_priority();
        do_reset();
        tx_empty_irq = 1;
        put_char(5'd1);
        chk("R7 thre code", iir_code, 8'hC2);
        run_ticks(640);
        chk("R7 timeout over thre", iir_code, 8'hCC);
        @(negedge clk);
        fifo_level = 5'd4;
        #1;
        chk("R7 rda over timeout", iir_code, 8'hC4);
        fifo_on = 0; rx_irq_en = 0;
        #1;
        chk("R7 non-fifo thre code", iir_code, 8'h02);
    endtask

    task automatic t_disabled();
        do_reset();
        rx_irq_en = 0;
        put_char(5'd1);
        run_ticks(800);
        chk("R1 irq disabled no timeout", to_pending, 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        put_char(5'd1); put_char(5'd2);
        run_ticks(639);
        @(negedge clk);
        os_tick = 1; rx_read_stb = 1;
        @(negedge clk);
        os_tick = 0; rx_read_stb = 0;
        chk("R9 restart beats tick", to_pending, 0);
        limit_edge("R9 full interval after restart", 640);
        @(negedge clk);
        rx_char_stb = 1; rx_read_stb = 1;
        @(negedge clk);
        rx_char_stb = 0; rx_read_stb = 0;
        chk("R4 read with char clears", to_pending, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_8n1();
        t_read_clear();
        t_formats();
        t_char_restart();
        t_trig_one();
        t_empty();
        t_priority();
        t_disabled();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule